// File: doc/BRIEF.md
# I2C Write-Only Register Target

This block is a target on a two-wire serial control bus. It takes write transfers into a bank of eight 8-bit control registers that sits outside the block. Both bus lines are sampled by the system clock. They pass through a short synchroniser and an agreement filter, and then edge logic finds the SCL edges and the START and STOP conditions.

A transfer opens with a START and an address byte. That byte carries the 7-bit device address, MSB first, followed by a direction bit where 0 means write. A sub-address byte comes next. Its low three bits choose a register, bit 3 turns on auto-increment, and bits 7:4 are not used. Each data byte after that produces a one-cycle write strobe, with index and data, towards the register bank. The target acknowledges a byte by enabling an open-drain pull-down on SDA during the ninth clock.

Top module: `i2c_reg_wr_port`

## Requirements
- R1: After reset, `sda_oe_o` and `wr_en_o` are both low.
- R2: After a START, an address byte that equals `DEV_ADDR` in bits 7:1 and has bit 0 = 0 (write) is acknowledged: `sda_oe_o` is high while SCL is high in the ninth clock, and it is released after that clock.
- R3: An address byte that does not match, or that has bit 0 = 1 (read), is not acknowledged. No later byte is acknowledged or written until the next START.
- R4: The byte after an acknowledged address is always acknowledged. Its bits 2:0 are the start index and bit 3 is the increment flag. Bits 7:4 do not affect which register is written.
- R5: With increment flag 0, exactly one data byte is written, to the selected index. Later data bytes in the same transfer are neither acknowledged nor written.
- R6: With increment flag 1, successive data bytes are written to index, index+1, and so on. Index 7 is followed by index 0.
- R7: A repeated START after the sub-address restarts address reception and causes no write.
- R8: After a STOP, clocked bytes without a new START are neither acknowledged nor written.
- R9: Each accepted data byte gives a single-cycle `wr_en_o` pulse carrying the index and data. The pulse coincides with the start of its acknowledge drive.
- R10: `sda_oe_o` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line (asynchronous) |
| sda_i | input | 1 | Bus data line as seen at the pad (asynchronous) |
| sda_oe_o | output | 1 | Pull SDA low when high (open-drain enable) |
| wr_en_o | output | 1 | Register write strobe, one cycle |
| wr_idx_o | output | 3 | Register index for the write |
| wr_data_o | output | 8 | Data byte for the write |

## Verification
The checker watches two things on every cycle. It checks that the write strobe is a single cycle and always comes with an acknowledge drive (R9). It checks that the SDA enable rises and falls only while SCL is low (R10). Only the bench scenarios can show the rest: the address and direction decode, how the sub-address splits into index and flag, the single-write rule against the increment rule with its wrap from 7 to 0, and that repeated START, STOP and rejected addresses leave the register bank untouched. The scoreboard checks each of these against the exact sequence of index and data pairs it expects.

// File: rtl/i2c_wr_pkg.sv
package i2c_wr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SUB,
    ST_DATA,
    ST_SKIP
  } i2c_st_e;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/i2c_in_sync.sv
module i2c_in_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int LastS = STAGES - 1;

  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    logic              held_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chain_q <= '1;
        held_q  <= 1'b1;
      end else begin
        chain_q <= {chain_q[LastS-1:0], d_i[g]};
        // accept a new level only when two samples agree
        if (chain_q[LastS] == chain_q[LastS-1]) held_q <= chain_q[LastS];
      end
    end
    assign q_o[g] = held_q;
  end
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_i;
      sda_d <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_d;
  assign scl_fall_o = ~scl_i & scl_d;
  assign start_o    = scl_i & scl_d & sda_d & ~sda_i;
  assign stop_o     = scl_i & scl_d & ~sda_d & sda_i;
endmodule

// File: rtl/i2c_reg_wr_port.sv
module i2c_reg_wr_port
  import i2c_wr_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR   = 7'h42,
  parameter int         IDX_W      = 3,
  parameter int         SYNC_STAGE = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [BYTE_W-1:0] wr_data_o
);
  localparam int CntW    = $clog2(BYTE_W + 1);
  localparam int IncBit  = IDX_W;
  localparam logic [CntW-1:0] FullCnt = CntW'(BYTE_W);

  logic [1:0] line_s;
  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

  i2c_in_sync #(.WIDTH(2), .STAGES(SYNC_STAGE)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (line_s)
  );
  assign scl_s = line_s[1];
  assign sda_s = line_s[0];

  i2c_bus_events u_ev (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_s),
    .sda_i     (sda_s),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start_ev),
    .stop_o    (stop_ev)
  );

  i2c_st_e           st_q;
  logic [CntW-1:0]   bit_cnt_q;
  logic [BYTE_W-1:0] sr_q;
  logic              ack_ph_q, oe_q, inc_q, wr_en_q;
  logic [IDX_W-1:0]  idx_q, wr_idx_q;
  logic [BYTE_W-1:0] wr_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      bit_cnt_q <= '0;
      sr_q      <= '0;
      ack_ph_q  <= 1'b0;
      oe_q      <= 1'b0;
      inc_q     <= 1'b0;
      idx_q     <= '0;
      wr_en_q   <= 1'b0;
      wr_idx_q  <= '0;
      wr_data_q <= '0;
    end else begin
      wr_en_q <= 1'b0;
      if (start_ev) begin
        st_q      <= ST_ADDR;
        bit_cnt_q <= '0;
        ack_ph_q  <= 1'b0;
        oe_q      <= 1'b0;
      end else if (stop_ev) begin
        st_q      <= ST_IDLE;
        bit_cnt_q <= '0;
        ack_ph_q  <= 1'b0;
        oe_q      <= 1'b0;
      end else if (st_q != ST_IDLE) begin
        if (scl_rise && !ack_ph_q && bit_cnt_q != FullCnt) begin
          sr_q      <= {sr_q[BYTE_W-2:0], sda_s};
          bit_cnt_q <= bit_cnt_q + 1'b1;
        end else if (scl_fall && ack_ph_q) begin
          // end of ninth clock: release the line
          ack_ph_q  <= 1'b0;
          oe_q      <= 1'b0;
          bit_cnt_q <= '0;
        end else if (scl_fall && bit_cnt_q == FullCnt) begin
          ack_ph_q <= 1'b1;
          unique case (st_q)
            ST_ADDR: begin
              if (sr_q[7:1] == DEV_ADDR && !sr_q[0]) begin
                oe_q <= 1'b1;
                st_q <= ST_SUB;
              end else begin
                st_q <= ST_SKIP;
              end
            end
            ST_SUB: begin
              oe_q  <= 1'b1;
              idx_q <= sr_q[IDX_W-1:0];
              inc_q <= sr_q[IncBit];
              st_q  <= ST_DATA;
            end
            ST_DATA: begin
              oe_q      <= 1'b1;
              wr_en_q   <= 1'b1;
              wr_idx_q  <= idx_q;
              wr_data_q <= sr_q;
              if (inc_q) idx_q <= idx_q + 1'b1;
              else       st_q  <= ST_SKIP;
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign sda_oe_o  = oe_q;
  assign wr_en_o   = wr_en_q;
  assign wr_idx_o  = wr_idx_q;
  assign wr_data_o = wr_data_q;
endmodule

// File: rtl/i2c_reg_wr_port_chk.sv
module i2c_reg_wr_port_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_i,
  input logic sda_oe_o,
  input logic wr_en_o
);
  assert_wr_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o);

  assert_wr_acked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> sda_oe_o);

  assert_oe_rise_scl_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_i);

  assert_oe_fall_scl_low_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_oe_o) |-> !scl_i);
endmodule

bind i2c_reg_wr_port i2c_reg_wr_port_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .scl_i   (scl_i),
  .sda_oe_o(sda_oe_o),
  .wr_en_o (wr_en_o)
);

// File: tb/tb_i2c_reg_wr_port.sv
module tb_i2c_reg_wr_port;
  localparam logic [6:0] ADDR = 7'h42;
  localparam int Q = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, wr_en;
  logic [2:0] wr_idx;
  logic [7:0] wr_data;
  wire  sda_line = sda_m & ~sda_oe;

  int checks = 0, errors = 0, r10_viol = 0, cyc = 0;
  bit finished = 0;
  logic [10:0] exp_q[$];
  string       tag_q[$];
  logic prev_wr = 1'b0, prev_oe = 1'b0;

  always #5 clk = ~clk;

  i2c_reg_wr_port #(.DEV_ADDR(ADDR)) dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hold();
    scl_m = 1'b1; hold();
    sda_m = 1'b0; hold();
    scl_m = 1'b0; hold();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold();
    scl_m = 1'b1; hold();
    sda_m = 1'b1; hold();
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hold();
      scl_m = 1'b1; hold();
      scl_m = 1'b0; hold();
    end
    sda_m = 1'b1; hold();
    scl_m = 1'b1; hold();
    check((!sda_line) == exp_ack, req, !sda_line, exp_ack);
    scl_m = 1'b0; hold();
  endtask

  task automatic expect_wr(input logic [2:0] idx, input logic [7:0] d, input string req);
    exp_q.push_back({idx, d});
    tag_q.push_back(req);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (scl_m && sda_oe != prev_oe) r10_viol++;
      if (wr_en) begin
        check(!prev_wr, "R9 pulse width", prev_wr, 0);
        check(sda_oe, "R9 ack with write", sda_oe, 1);
        if (exp_q.size() == 0) begin
          check(0, "R3/R5/R7/R8 unexpected write", {wr_idx, wr_data}, 0);
        end else begin
          automatic logic [10:0] e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          check({wr_idx, wr_data} == e, t, {wr_idx, wr_data}, e);
        end
      end
      prev_wr = wr_en;
      prev_oe = sda_oe;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(!sda_oe && !wr_en, "R1 reset outputs", {sda_oe, wr_en}, 0);
    rst_n = 1'b1;
    hold();

    // single write, extra byte rejected
    bus_start();
    send_byte({ADDR, 1'b0}, 1, "R2 address ack");
    send_byte(8'h03, 1, "R4 sub ack");
    expect_wr(3'd3, 8'hA5, "R5 single write");
    send_byte(8'hA5, 1, "R5 data ack");
    send_byte(8'h11, 0, "R5 extra byte nack");
    bus_stop();
    check(!sda_oe, "R2 released", sda_oe, 0);

    // auto-increment with wrap
    bus_start();
    send_byte({ADDR, 1'b0}, 1, "R2 address ack");
    send_byte(8'h0E, 1, "R4 sub ack inc");
    expect_wr(3'd6, 8'h01, "R6 inc idx6");
    send_byte(8'h01, 1, "R6 data ack");
    expect_wr(3'd7, 8'h02, "R6 inc idx7");
    send_byte(8'h02, 1, "R6 data ack");
    expect_wr(3'd0, 8'h03, "R6 wrap idx0");
    send_byte(8'h03, 1, "R6 data ack");
    bus_stop();

    // wrong address
    bus_start();
    send_byte({ADDR ^ 7'h01, 1'b0}, 0, "R3 mismatch nack");
    send_byte(8'h08, 0, "R3 ignored byte");
    send_byte(8'hCC, 0, "R3 ignored byte");
    bus_stop();

    // read request
    bus_start();
    send_byte({ADDR, 1'b1}, 0, "R3 read nack");
    send_byte(8'h44, 0, "R3 ignored byte");
    bus_stop();

    // repeated start, top sub bits set
    bus_start();
    send_byte({ADDR, 1'b0}, 1, "R7 address ack");
    send_byte(8'h09, 1, "R7 sub ack");
    bus_start();
    send_byte({ADDR, 1'b0}, 1, "R7 readdress ack");
    send_byte(8'hF5, 1, "R4 sub ack high bits");
    expect_wr(3'd5, 8'h5A, "R4 high bits ignored");
    send_byte(8'h5A, 1, "R4 data ack");
    bus_stop();

    // bytes after stop, then recovery
    send_byte(8'h84, 0, "R8 no start nack");
    send_byte(8'h0A, 0, "R8 no start nack");
    bus_start();
    send_byte({ADDR, 1'b0}, 1, "R8 recovery ack");
    send_byte(8'h02, 1, "R8 sub ack");
    expect_wr(3'd2, 8'h77, "R8 recovery write");
    send_byte(8'h77, 1, "R8 data ack");
    bus_stop();
    hold();

    check(exp_q.size() == 0, "R5/R6 all writes seen", exp_q.size(), 0);
    check(r10_viol == 0, "R10 oe stable while SCL high", r10_viol, 0);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule